// File: doc/BRIEF.md
# Two-Wire Serial Byte Shifter with Slave Address Recognition

This block is the byte-level datapath of a two-wire serial slave. One 8-bit register serves both directions. When sending, it holds the next byte and presents its top bit on the data line. When receiving, it keeps the last byte seen. Because the register samples the line on every clock rise, even while it drives, it always ends a byte holding what the bus really carried. A second register holds a 7-bit own address and a general-call enable. Every address byte that follows a START is compared against both.

Bit timing, START/STOP detection and clock stretching are done elsewhere and arrive as one-cycle strobes: `scl_rise`, `scl_fall`, `bus_start` and `bus_stop`. The CPU side sees the two registers and an interrupt flag. The flag rises when a byte plus its acknowledge slot is complete. Writing the clear strobe releases the next byte.

The control is a state machine with six states:
- `ST_IDLE` waits for START.
- `ST_ADDR` shifts in the address byte.
- `ST_ACK_A` is the address acknowledge slot.
- `ST_DATA` shifts one data byte.
- `ST_ACK_D` is the data acknowledge slot.
- `ST_HOLD` holds the flag set.

The transitions are:
- A START in any state goes to `ST_ADDR`.
- A STOP in any state goes to `ST_IDLE`.
- The eighth rise in `ST_ADDR` goes to `ST_ACK_A`.
- In `ST_ACK_A`, a rise goes to `ST_HOLD` on a match, otherwise to `ST_IDLE`.
- The eighth rise in `ST_DATA` goes to `ST_ACK_D`.
- A rise in `ST_ACK_D` goes to `ST_HOLD`.
- The flag clear in `ST_HOLD` goes to `ST_DATA`.

Top module: `tw_byte_shifter`

## Requirements
- R1: After reset the data register reads 0xFF, the address register reads 0xFE, `irq_flag` and `addr_match` are 0 and `sda_out` is 1 (released).
- R2: A CPU write to the data register takes effect in the next cycle only while `irq_flag` is 1; a write while the flag is 0 leaves the register unchanged.
- R3: While `irq_flag` stays 1 the data register changes only through a CPU write; clock strobes on the bus do not alter it.
- R4: Bits move MSB first. `sda_out` updates one cycle after an `scl_fall` strobe. `sda_in` is shifted into bit 0 one cycle after an `scl_rise` strobe. After eight rises the data register holds the byte on the bus, even where it differs from the byte driven.
- R5: An address byte matches when its bits 7..1 equal address register bits 7..1, or when bits 7..1 are all zero and address register bit 0 (general-call enable) is 1.
- R6: On a match the slave drives `sda_out` to 0 in the acknowledge slot. After the ninth rise, `irq_flag` and `addr_match` are 1, `rw_dir` equals bit 0 of the address byte, and `gen_call` is 1 exactly when the zero address was accepted through the enable.
- R7: A non-matching address is not acknowledged (`sda_out` stays 1), does not set `irq_flag`, and later clocks are ignored until the next START.
- R8: In a receive data byte (`rw_dir` 0), `sda_out` is 0 in the acknowledge slot and `irq_flag` is 1 one cycle after the ninth rise.
- R9: In a transmit data byte (`rw_dir` 1), `sda_out` is released (1) in the acknowledge slot, and `ack_rcvd` becomes the inverse of `sda_in` sampled at the ninth rise.
- R10: `cpu_flag_clr` while `irq_flag` is 1 clears the flag in the next cycle and starts the next byte; when transmitting, `sda_out` shows bit 7 of the data register in that same cycle.
- R11: `bus_stop` returns the block to idle in the next cycle: `sda_out` 1, `irq_flag` 0, `addr_match` 0.
- R12: The address register can be written at any time and reads back the written value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_data_wr | input | 1 | Data register write strobe |
| cpu_data_wdata | input | 8 | Data register write value |
| cpu_data_rdata | output | 8 | Data register contents |
| cpu_addr_wr | input | 1 | Address register write strobe |
| cpu_addr_wdata | input | 8 | Address register write value: own address in 7..1, general-call enable in 0 |
| cpu_addr_rdata | output | 8 | Address register contents |
| cpu_flag_clr | input | 1 | Write-one strobe that clears the interrupt flag |
| bus_start | input | 1 | START condition strobe |
| bus_stop | input | 1 | STOP condition strobe |
| scl_rise | input | 1 | Serial clock rising strobe |
| scl_fall | input | 1 | Serial clock falling strobe |
| sda_in | input | 1 | Serial data line level |
| sda_out | output | 1 | Serial data drive, 0 pulls low, 1 releases |
| irq_flag | output | 1 | Interrupt flag, byte and acknowledge complete |
| addr_match | output | 1 | Own or general-call address accepted |
| gen_call | output | 1 | Accepted address was the general call |
| rw_dir | output | 1 | Direction bit of the accepted address, 1 means slave transmits |
| ack_rcvd | output | 1 | Acknowledge seen from the master after a transmitted byte |

## Verification
Every result lands exactly one clock after its stimulus strobe, since each is a single register stage:
- `sda_out` follows an `scl_fall`, a `cpu_flag_clr` or a STOP by one cycle.
- The data register, `irq_flag`, `addr_match`, `rw_dir`, `gen_call` and `ack_rcvd` follow an `scl_rise` by one cycle.

The bench drives each strobe for one cycle starting at a falling clock edge and drops it at the next falling edge. It samples there, one rising edge after the strobe was taken.

The sweeps cover all 128 received addresses against three programmed addresses with the general-call enable both off and on. They also cover all 256 bytes in the receive direction and all 256 in the transmit direction, with a third of the transmitted bytes corrupted on the bus.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_ACK_A = 3'd2,
        ST_DATA  = 3'd3,
        ST_ACK_D = 3'd4,
        ST_HOLD  = 3'd5
    } tw_state_e;

endpackage

// File: rtl/tw_data_reg.sv
module tw_data_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '1;
        end else if (load_en) begin
            q <= load_val;
        end else if (shift_en) begin
            q <= {q[WIDTH-2:0], shift_in};
        end
    end

endmodule

// File: rtl/tw_addr_unit.sv
module tw_addr_unit #(
    parameter int ADDR_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [ADDR_W:0] wr_val,
    input  logic [ADDR_W:0] rx_byte,
    output logic [ADDR_W:0] reg_q,
    output logic          own_hit,
    output logic          gc_hit
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= {{ADDR_W{1'b1}}, 1'b0};
        end else if (wr_en) begin
            reg_q <= wr_val;
        end
    end

    // Direction bit (bit 0 of the received byte) takes no part in the compare.
    always_comb begin
        own_hit = (rx_byte[ADDR_W:1] == reg_q[ADDR_W:1]);
        gc_hit  = reg_q[0] && (rx_byte[ADDR_W:1] == '0);
    end

endmodule

// File: rtl/tw_bit_counter.sv
module tw_bit_counter #(
    parameter int COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CNT_W = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(COUNT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= (cnt_q == LAST_VAL) ? '0 : cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/tw_byte_shifter.sv
module tw_byte_shifter
    import tw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_data_wr,
    input  logic [DATA_W-1:0] cpu_data_wdata,
    output logic [DATA_W-1:0] cpu_data_rdata,
    input  logic              cpu_addr_wr,
    input  logic [DATA_W-1:0] cpu_addr_wdata,
    output logic [DATA_W-1:0] cpu_addr_rdata,
    input  logic              cpu_flag_clr,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    output logic              sda_out,
    output logic              irq_flag,
    output logic              addr_match,
    output logic              gen_call,
    output logic              rw_dir,
    output logic              ack_rcvd
);

    localparam int ADDR_W = DATA_W - 1;
    localparam int MSB    = DATA_W - 1;

    tw_state_e state_q, state_d;

    logic [DATA_W-1:0] data_q;
    logic              own_hit, gc_hit, any_hit;
    logic              shifting, shift_en, data_load;
    logic              cnt_clr, cnt_last;
    logic              hold_release;

    logic sda_q, match_q, gc_q, rw_q, tx_q, ack_q;

    // ---------------------------------------------------------------
    // Datapath
    // ---------------------------------------------------------------
    assign shifting     = (state_q == ST_ADDR) || (state_q == ST_DATA);
    assign shift_en     = shifting && scl_rise;
    assign data_load    = cpu_data_wr && (state_q == ST_HOLD);
    assign hold_release = (state_q == ST_HOLD) && cpu_flag_clr;
    assign cnt_clr      = bus_start || bus_stop || hold_release;
    assign any_hit      = own_hit || gc_hit;

    tw_data_reg #(.WIDTH(DATA_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (data_load),
        .load_val (cpu_data_wdata),
        .shift_en (shift_en),
        .shift_in (sda_in),
        .q        (data_q)
    );

    tw_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cpu_addr_wr),
        .wr_val  (cpu_addr_wdata),
        .rx_byte (data_q),
        .reg_q   (cpu_addr_rdata),
        .own_hit (own_hit),
        .gc_hit  (gc_hit)
    );

    tw_bit_counter #(.COUNT(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (shift_en),
        .last  (cnt_last)
    );

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        if (bus_stop) begin
            state_d = ST_IDLE;
        end else if (bus_start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ADDR:  if (scl_rise && cnt_last) state_d = ST_ACK_A;
                ST_ACK_A: if (scl_rise) state_d = any_hit ? ST_HOLD : ST_IDLE;
                ST_DATA:  if (scl_rise && cnt_last) state_d = ST_ACK_D;
                ST_ACK_D: if (scl_rise) state_d = ST_HOLD;
                ST_HOLD:  if (cpu_flag_clr) state_d = ST_DATA;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Registered outputs
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q   <= 1'b1;
            match_q <= 1'b0;
            gc_q    <= 1'b0;
            rw_q    <= 1'b0;
            tx_q    <= 1'b0;
            ack_q   <= 1'b0;
        end else if (bus_start || bus_stop) begin
            sda_q   <= 1'b1;
            match_q <= 1'b0;
            gc_q    <= 1'b0;
            rw_q    <= 1'b0;
            tx_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (scl_fall) sda_q <= 1'b1;
                end
                ST_ADDR: begin
                    if (scl_fall) sda_q <= 1'b1;
                end
                ST_ACK_A: begin
                    if (scl_fall) sda_q <= ~any_hit;
                    if (scl_rise && any_hit) begin
                        match_q <= 1'b1;
                        gc_q    <= gc_hit;
                        rw_q    <= data_q[0];
                        tx_q    <= data_q[0];
                    end
                end
                ST_DATA: begin
                    if (scl_fall) sda_q <= tx_q ? data_q[MSB] : 1'b1;
                end
                ST_ACK_D: begin
                    if (scl_fall) sda_q <= tx_q;
                    if (scl_rise && tx_q) ack_q <= ~sda_in;
                end
                ST_HOLD: begin
                    if (cpu_flag_clr) begin
                        sda_q <= tx_q ? data_q[MSB] : 1'b1;
                    end else if (scl_fall) begin
                        sda_q <= 1'b1;
                    end
                end
                default: sda_q <= 1'b1;
            endcase
        end
    end

    assign cpu_data_rdata = data_q;
    assign sda_out        = sda_q;
    assign irq_flag       = (state_q == ST_HOLD);
    assign addr_match     = match_q;
    assign gen_call       = gc_q;
    assign rw_dir         = rw_q;
    assign ack_rcvd       = ack_q;

endmodule

// File: rtl/tw_byte_shifter_chk.sv
module tw_byte_shifter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_data_wr,
    input logic [DATA_W-1:0] cpu_data_rdata,
    input logic              cpu_flag_clr,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              scl_rise,
    input logic              sda_out,
    input logic              irq_flag,
    input logic              addr_match
);

    // R2: a write while the flag is low must not land in the data register
    a_r2_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_data_wr) && !$past(irq_flag) && !$past(scl_rise))
        |-> (cpu_data_rdata == $past(cpu_data_rdata)));

    // R3: data register frozen while the flag stays set, barring CPU writes
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && $past(irq_flag) && !$past(cpu_data_wr))
        |-> (cpu_data_rdata == $past(cpu_data_rdata)));

    // R6 / R8: the flag only rises on a serial clock rise
    a_r6_flag_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(scl_rise));

    // R10: clearing the flag takes effect in the next cycle
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && cpu_flag_clr && !bus_start && !bus_stop) |=> !irq_flag);

    // R11: STOP returns to idle
    a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (sda_out && !irq_flag && !addr_match));

endmodule

bind tw_byte_shifter tw_byte_shifter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_data_wr    (cpu_data_wr),
    .cpu_data_rdata (cpu_data_rdata),
    .cpu_flag_clr   (cpu_flag_clr),
    .bus_start      (bus_start),
    .bus_stop       (bus_stop),
    .scl_rise       (scl_rise),
    .sda_out        (sda_out),
    .irq_flag       (irq_flag),
    .addr_match     (addr_match)
);

// File: tb/tw_byte_shifter_bench.sv
module tw_byte_shifter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_data_wr = 1'b0;
    logic [7:0] cpu_data_wdata = 8'h00;
    logic [7:0] cpu_data_rdata;
    logic       cpu_addr_wr = 1'b0;
    logic [7:0] cpu_addr_wdata = 8'h00;
    logic [7:0] cpu_addr_rdata;
    logic       cpu_flag_clr = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       scl_rise = 1'b0;
    logic       scl_fall = 1'b0;
    logic       sda_in = 1'b1;
    logic       sda_out, irq_flag, addr_match, gen_call, rw_dir, ack_rcvd;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    tw_byte_shifter u_tw_byte_shifter (
        .clk(clk), .rst_n(rst_n),
        .cpu_data_wr(cpu_data_wr), .cpu_data_wdata(cpu_data_wdata), .cpu_data_rdata(cpu_data_rdata),
        .cpu_addr_wr(cpu_addr_wr), .cpu_addr_wdata(cpu_addr_wdata), .cpu_addr_rdata(cpu_addr_rdata),
        .cpu_flag_clr(cpu_flag_clr), .bus_start(bus_start), .bus_stop(bus_stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .sda_out(sda_out),
        .irq_flag(irq_flag), .addr_match(addr_match), .gen_call(gen_call),
        .rw_dir(rw_dir), .ack_rcvd(ack_rcvd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic do_fall();
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
    endtask

    task automatic do_rise(input logic b);
        @(negedge clk) begin sda_in = b; scl_rise = 1'b1; end
        @(negedge clk) scl_rise = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) cpu_flag_clr = 1'b1;
        @(negedge clk) cpu_flag_clr = 1'b0;
    endtask

    task automatic write_data(input logic [7:0] v);
        @(negedge clk) begin cpu_data_wr = 1'b1; cpu_data_wdata = v; end
        @(negedge clk) cpu_data_wr = 1'b0;
    endtask

    task automatic write_addr(input logic [7:0] v);
        @(negedge clk) begin cpu_addr_wr = 1'b1; cpu_addr_wdata = v; end
        @(negedge clk) cpu_addr_wr = 1'b0;
    endtask

    // START, eight address bits, acknowledge slot; returns the slave's ack drive
    task automatic send_addr(input logic [6:0] a, input logic rw, output logic ack);
        logic [7:0] byt;
        byt = {a, rw};
        do_start();
        for (int i = 7; i >= 0; i--) begin
            do_fall();
            do_rise(byt[i]);
        end
        do_fall();
        ack = sda_out;
        do_rise(ack);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary_and_end();
    end

    initial begin
        logic ack;
        logic [6:0] own;
        logic m;
        logic [7:0] bus;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 data", cpu_data_rdata, 8'hFF);
        chk("R1 addr", cpu_addr_rdata, 8'hFE);
        chk("R1 irq", irq_flag, 1'b0);
        chk("R1 sda", sda_out, 1'b1);
        chk("R1 match", addr_match, 1'b0);

        // R2 write ignored with flag clear
        write_data(8'h12);
        chk("R2 idle write", cpu_data_rdata, 8'hFF);

        // R5 R6 R7 R12 address sweep
        for (int g = 0; g < 2; g++) begin
            for (int k = 0; k < 3; k++) begin
                own = (k == 0) ? 7'h00 : (k == 1) ? 7'h55 : 7'h7F;
                write_addr({own, g[0]});
                chk("R12 addr readback", cpu_addr_rdata, {own, g[0]});
                for (int a = 0; a < 128; a++) begin
                    m = (a[6:0] == own) || (g[0] && a[6:0] == 7'h00);
                    send_addr(a[6:0], a[0], ack);
                    chk("R6 ack drive", ack, !m);
                    chk("R5 irq", irq_flag, m);
                    chk("R5 match", addr_match, m);
                    if (m) begin
                        chk("R6 rw", rw_dir, a[0]);
                        chk("R6 gencall", gen_call, (g[0] && a[6:0] == 7'h00) ? 1'b1 : 1'b0);
                    end
                    do_stop();
                    chk("R11 stop sda", sda_out, 1'b1);
                    chk("R11 stop match", addr_match, 1'b0);
                end
            end
        end

        // R7 later clocks ignored after unmatched address
        write_addr(8'hAA);  // own address 0x55, general call off
        send_addr(7'h33, 1'b0, ack);
        for (int i = 0; i < 8; i++) begin
            do_fall();
            do_rise(1'b0);
        end
        do_fall();
        do_rise(1'b0);
        chk("R7 ignored irq", irq_flag, 1'b0);
        chk("R7 ignored data", cpu_data_rdata, 8'h66);
        chk("R7 ignored sda", sda_out, 1'b1);

        // R8 receive sweep
        send_addr(7'h55, 1'b0, ack);
        chk("R6 rx ack", ack, 1'b0);
        for (int v = 0; v < 256; v++) begin
            do_clear();
            chk("R10 clr", irq_flag, 1'b0);
            for (int i = 7; i >= 0; i--) begin
                do_fall();
                if (i == 4) write_data(8'hA5);
                do_rise(v[i]);
            end
            do_fall();
            chk("R8 rx ack", sda_out, 1'b0);
            do_rise(1'b0);
            chk("R8 irq", irq_flag, 1'b1);
            chk("R4 rx data", cpu_data_rdata, v[7:0]);
            do_rise(~v[0]);
            do_fall();
            repeat (2) @(negedge clk);
            chk("R3 hold data", cpu_data_rdata, v[7:0]);
        end
        do_stop();

        // R9 transmit sweep, some bytes corrupted on the bus
        send_addr(7'h55, 1'b1, ack);
        chk("R6 tx rw", rw_dir, 1'b1);
        for (int v = 0; v < 256; v++) begin
            bus = (v % 3 == 0) ? (v[7:0] & 8'h6D) : v[7:0];
            write_data(v[7:0]);
            chk("R2 hold write", cpu_data_rdata, v[7:0]);
            do_clear();
            chk("R10 clr irq", irq_flag, 1'b0);
            chk("R10 first bit", sda_out, v[7]);
            for (int i = 7; i >= 0; i--) begin
                do_fall();
                chk("R4 tx bit", sda_out, v[i]);
                do_rise(bus[i]);
            end
            do_fall();
            chk("R9 release", sda_out, 1'b1);
            do_rise(v[0]);
            chk("R9 ack", ack_rcvd, !v[0]);
            chk("R4 bus byte", cpu_data_rdata, bus);
            chk("R9 irq", irq_flag, 1'b1);
        end

        // R11 stop mid-byte
        do_clear();
        do_fall();
        do_rise(1'b1);
        do_stop();
        chk("R11 sda", sda_out, 1'b1);
        chk("R11 irq", irq_flag, 1'b0);
        chk("R11 match", addr_match, 1'b0);
        for (int i = 0; i < 9; i++) begin
            do_fall();
            do_rise(1'b0);
        end
        chk("R11 stays idle", irq_flag, 1'b0);

        summary_and_end();
    end

endmodule